// File: doc/BRIEF.md
# Prescaled Pulse Counter with Residue Recovery

This block measures a pulse stream that is too fast to count directly. The stream goes through an external divide-by-N prescaler, and the block counts only the prescaler's overflow strobes while a measurement is open. When the measurement is closed, the block gates the live stream away from the prescaler. It then clocks the prescaler by hand, one manual pulse at a time, until the next overflow strobe comes back.

The number of manual pulses that were needed shows how far the prescaler had advanced past its last wrap. The block never reads the prescaler's internal state. The full-resolution result is the overflow count times N plus the recovered residue. Because the recovery ends exactly on a wrap, the prescaler is left at zero, and the next measurement starts from a clean divider.

Software or a sequencer opens a measurement with a start strobe and closes it with a stop strobe, then waits for the valid strobe. N is a power of two, so the overflow count fills the upper bits of the result and the residue fills the lower log2(N) bits.

Top module: `psc_residue_counter`

## Requirements
- R1: While reset is high and in the first cycle after it, gate_en_o, man_pulse_o, valid_o and err_o are 0 and count_o is 0.
- R2: A start strobe while idle raises gate_en_o in the next cycle and clears the overflow tally. A start strobe during a running measurement is ignored and the tally keeps running. If start and stop arrive together while idle, start wins.
- R3: A stop strobe during acquisition drops gate_en_o in the next cycle. A stop strobe while idle is ignored: no manual pulse and no valid follow.
- R4: Every rising edge of the synchronised ovf_i is tallied while gate_en_o is high. Edges are also tallied for SYNC_STAGES+2 cycles after stop, so an overflow in flight at the stop, including one whose edge lands in the stop cycle, is counted.
- R5: After that drain window, manual pulses are issued. Each is high for exactly one cycle and is followed by SYNC_STAGES+2 low cycles. gate_en_o stays low for the whole recovery.
- R6: Manual pulsing stops at the first synchronised overflow edge seen during a low phase. The recorded count m includes the pulse that caused that edge, so m is between 1 and N. The prescaler must answer a pulse within one clock.
- R7: count_o = tally*N + (N - m), truncated to OVF_W+log2(N) bits. The tally occupies bits [OVF_W+log2(N)-1 : log2(N)] and the residue occupies the low log2(N) bits. A residue of 0 therefore takes m = N pulses.
- R8: valid_o is a one-cycle strobe. count_o and err_o change only together with valid_o and hold their values until the next valid_o.
- R9: If no overflow is seen after N manual pulses, err_o is 1, the residue field is 0, and valid_o is still strobed. A later good measurement returns err_o to 0.
- R10: Activity on the live pulse path while idle or during recovery has no effect on the result, because the prescaler receives no live pulses then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Open a measurement (one-cycle strobe) |
| stop_i | input | 1 | Close the measurement (one-cycle strobe) |
| ovf_i | input | 1 | Overflow strobe from the external prescaler, asynchronous |
| gate_en_o | output | 1 | Passes live pulses to the prescaler when high |
| man_pulse_o | output | 1 | Manual clock pulse to the prescaler |
| count_o | output | OVF_W+DIV_LOG2 | Full-resolution pulse count |
| valid_o | output | 1 | One-cycle strobe: count_o and err_o updated |
| err_o | output | 1 | Residue recovery saw no overflow within N pulses |

## Verification
The delicate coincidence is an overflow edge arriving in the same cycle that a stop is taken. At that moment, tallying during acquisition and entering the drain window compete for the same edge. The bench makes the final, wrapping live pulse land 0 to 4 cycles before the stop strobe, which walks the synchronised edge across the stop cycle. Each case must return exactly 2*N with N manual pulses, since an edge counted twice or dropped would shift the result by N. A start and a stop given in the same idle cycle are also judged, by the gate opening and by a correct count from that measurement.

// File: rtl/psc_pkg.sv
package psc_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_ACQ,
        SEQ_DRAIN,
        SEQ_PULSE_HI,
        SEQ_PULSE_LO
    } seq_state_e;

    typedef struct packed {
        logic gate_en;
        logic man_pulse;
        logic count_en;
    } seq_ctl_s;

    // Cycles from a manual pulse (or a stop) until the prescaler's answer
    // is visible through the synchroniser, with one cycle of margin.
    function automatic int unsigned pulse_space(input int unsigned sync_stages);
        return sync_stages + 2;
    endfunction

endpackage

// File: rtl/psc_sync_edge.sv
module psc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    logic synced;
    logic prev_q;

    generate
        if (STAGES == 1) begin : g_single
            logic s_q;
            always_ff @(posedge clk) begin
                if (rst) s_q <= 1'b0;
                else     s_q <= async_i;
            end
            assign synced = s_q;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], async_i};
            end
            assign synced = chain_q[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= synced;
    end

    assign rise_o = synced & ~prev_q;
endmodule

// File: rtl/psc_ovf_counter.sv
module psc_ovf_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic         rise_i,
    output logic [W-1:0] cnt_o
);
    always_ff @(posedge clk) begin
        if (rst || clr_i)       cnt_o <= '0;
        else if (en_i && rise_i) cnt_o <= cnt_o + W'(1);
    end
endmodule

// File: rtl/psc_sequencer.sv
module psc_sequencer #(
    parameter int DIV_LOG2    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic                  stop_i,
    input  logic                  rise_i,
    output psc_pkg::seq_ctl_s     ctl_o,
    output logic                  clr_o,
    output logic                  done_o,
    output logic                  err_o,
    output logic [DIV_LOG2:0]     mcnt_o
);
    import psc_pkg::*;

    localparam int DIV   = 1 << DIV_LOG2;
    localparam int SPACE = int'(pulse_space(SYNC_STAGES));
    localparam int TW    = $clog2(SPACE + 1);
    localparam logic [TW-1:0]     WAIT_LAST = TW'(SPACE - 1);
    localparam logic [DIV_LOG2:0] M_LIMIT   = (DIV_LOG2 + 1)'(DIV);

    seq_state_e        state_q;
    logic [TW-1:0]     wait_q;
    logic [DIV_LOG2:0] mcnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            wait_q  <= '0;
            mcnt_q  <= '0;
            done_o  <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    if (start_i) state_q <= SEQ_ACQ;
                end
                SEQ_ACQ: begin
                    if (stop_i) begin
                        state_q <= SEQ_DRAIN;
                        wait_q  <= '0;
                    end
                end
                SEQ_DRAIN: begin
                    if (wait_q == WAIT_LAST) begin
                        state_q <= SEQ_PULSE_HI;
                        mcnt_q  <= '0;
                    end else begin
                        wait_q <= wait_q + TW'(1);
                    end
                end
                SEQ_PULSE_HI: begin
                    mcnt_q  <= mcnt_q + (DIV_LOG2 + 1)'(1);
                    wait_q  <= '0;
                    state_q <= SEQ_PULSE_LO;
                end
                SEQ_PULSE_LO: begin
                    if (rise_i) begin
                        done_o  <= 1'b1;
                        err_o   <= 1'b0;
                        state_q <= SEQ_IDLE;
                    end else if (wait_q == WAIT_LAST) begin
                        if (mcnt_q == M_LIMIT) begin
                            done_o  <= 1'b1;
                            err_o   <= 1'b1;
                            state_q <= SEQ_IDLE;
                        end else begin
                            state_q <= SEQ_PULSE_HI;
                        end
                    end else begin
                        wait_q <= wait_q + TW'(1);
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl_o.gate_en   = (state_q == SEQ_ACQ);
        ctl_o.man_pulse = (state_q == SEQ_PULSE_HI);
        ctl_o.count_en  = (state_q == SEQ_ACQ) || (state_q == SEQ_DRAIN);
    end

    assign clr_o  = (state_q == SEQ_IDLE) && start_i;
    assign mcnt_o = mcnt_q;
endmodule

// File: rtl/psc_residue_counter.sv
module psc_residue_counter #(
    parameter int DIV_LOG2    = 8,
    parameter int OVF_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start_i,
    input  logic                        stop_i,
    input  logic                        ovf_i,
    output logic                        gate_en_o,
    output logic                        man_pulse_o,
    output logic [OVF_W+DIV_LOG2-1:0]   count_o,
    output logic                        valid_o,
    output logic                        err_o
);
    localparam int CNT_W = OVF_W + DIV_LOG2;
    localparam int DIV   = 1 << DIV_LOG2;

    psc_pkg::seq_ctl_s ctl;
    logic              rise;
    logic              clr;
    logic              done;
    logic              seq_err;
    logic [DIV_LOG2:0] mcnt;
    logic [OVF_W-1:0]  tally;
    logic [DIV_LOG2:0] residue_full;

    psc_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .async_i(ovf_i), .rise_o(rise)
    );

    psc_ovf_counter #(.W(OVF_W)) tally_i (
        .clk(clk), .rst(rst), .clr_i(clr), .en_i(ctl.count_en),
        .rise_i(rise), .cnt_o(tally)
    );

    psc_sequencer #(.DIV_LOG2(DIV_LOG2), .SYNC_STAGES(SYNC_STAGES)) seq_i (
        .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
        .rise_i(rise), .ctl_o(ctl), .clr_o(clr), .done_o(done),
        .err_o(seq_err), .mcnt_o(mcnt)
    );

    // N - m; m == N leaves zero in the low bits.
    assign residue_full = (DIV_LOG2 + 1)'(DIV) - mcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_o <= '0;
            valid_o <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            valid_o <= done;
            if (done) begin
                count_o <= CNT_W'({tally, residue_full[DIV_LOG2-1:0]});
                err_o   <= seq_err;
            end
        end
    end

    assign gate_en_o   = ctl.gate_en;
    assign man_pulse_o = ctl.man_pulse;
endmodule

// File: rtl/psc_checker.sv
module psc_checker #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             stop_i,
    input logic             gate_en_o,
    input logic             man_pulse_o,
    input logic [CNT_W-1:0] count_o,
    input logic             valid_o,
    input logic             err_o
);
    AST_GATE_MAN_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(gate_en_o && man_pulse_o)); // R5

    AST_MAN_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        man_pulse_o |=> !man_pulse_o); // R5

    AST_STOP_CLOSES_GATE: assert property (@(posedge clk) disable iff (rst)
        (gate_en_o && stop_i) |=> !gate_en_o); // R3

    AST_VALID_STROBE: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o); // R8

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> ($stable(count_o) && $stable(err_o))); // R8

    AST_NO_VALID_WHILE_GATED: assert property (@(posedge clk) disable iff (rst)
        gate_en_o |-> !valid_o); // R6
endmodule

bind psc_residue_counter psc_checker #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst(rst), .stop_i(stop_i), .gate_en_o(gate_en_o),
    .man_pulse_o(man_pulse_o), .count_o(count_o), .valid_o(valid_o),
    .err_o(err_o)
);

// File: tb/psc_residue_counter_tb_top.sv
module psc_residue_counter_tb_top;
    localparam int DIV_LOG2 = 8;
    localparam int DIV      = 1 << DIV_LOG2;
    localparam int OVF_W    = 16;
    localparam int CNT_W    = OVF_W + DIV_LOG2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic stop_i = 1'b0;
    logic ovf_i;
    logic gate_en_o, man_pulse_o, valid_o, err_o;
    logic [CNT_W-1:0] count_o;

    logic live_t = 1'b0;
    logic noise_en = 1'b0;
    logic noise_q = 1'b0;
    logic stuck = 1'b0;
    logic live;
    int   pcnt = 0;
    int   ovf_hold = 0;
    int   mp_total = 0;
    int   viol = 0;
    int   n_total = 0;
    int   n_pass = 0;

    always #5 clk = ~clk;

    psc_residue_counter #(.DIV_LOG2(DIV_LOG2), .OVF_W(OVF_W), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i), .ovf_i(ovf_i),
        .gate_en_o(gate_en_o), .man_pulse_o(man_pulse_o), .count_o(count_o),
        .valid_o(valid_o), .err_o(err_o)
    );

    // Live pulse path and external divide-by-N prescaler model.
    assign live  = live_t | noise_q;
    assign ovf_i = (ovf_hold != 0) && !stuck;

    always @(negedge clk) noise_q <= noise_en ? ~noise_q : 1'b0;

    always @(posedge clk) begin
        if ((gate_en_o && live) || man_pulse_o) begin
            if (pcnt == DIV - 1) begin
                pcnt     <= 0;
                ovf_hold <= 2;
            end else begin
                pcnt     <= pcnt + 1;
                ovf_hold <= (ovf_hold > 0) ? ovf_hold - 1 : 0;
            end
        end else begin
            ovf_hold <= (ovf_hold > 0) ? ovf_hold - 1 : 0;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (man_pulse_o) mp_total <= mp_total + 1;
            if (man_pulse_o && gate_en_o) viol <= viol + 1;
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_pass, n_total);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_total++;
        if (ok) n_pass++;
        else $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    endtask

    task automatic strobe_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic strobe_stop();
        @(negedge clk) stop_i = 1'b1;
        @(negedge clk) stop_i = 1'b0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) live_t = 1'b1;
            @(negedge clk) live_t = 1'b0;
        end
    endtask

    // Last live pulse lands tail_d cycles before the stop strobe.
    task automatic train_then_stop(input int n, input int tail_d);
        if (n == 0) begin
            strobe_stop();
        end else begin
            pulses(n - 1);
            @(negedge clk) live_t = 1'b1;
            if (tail_d == 0) begin
                stop_i = 1'b1;
                @(negedge clk) begin live_t = 1'b0; stop_i = 1'b0; end
            end else begin
                @(negedge clk) live_t = 1'b0;
                repeat (tail_d - 1) @(negedge clk);
                strobe_stop();
            end
        end
    endtask

    task automatic wait_valid(output bit got, output longint c, output bit e);
        got = 1'b0; c = 0; e = 1'b0;
        for (int i = 0; i < 5000 && !got; i++) begin
            @(negedge clk);
            if (valid_o) begin
                got = 1'b1; c = longint'(count_o); e = err_o;
            end
        end
    endtask

    task automatic finish_meas(input int m0, input longint exp_c, input int exp_m,
                               input bit exp_e, input string req);
        bit got; longint c; bit e;
        wait_valid(got, c, e);
        chk(got, "R8", {req, " valid strobe"}, longint'(got), 1);
        chk(c == exp_c, req, "count_o", c, exp_c);
        chk(mp_total - m0 == exp_m, "R6", {req, " manual pulses"}, mp_total - m0, exp_m);
        chk(e == exp_e, "R9", {req, " err_o"}, longint'(e), longint'(exp_e));
        chk(viol == 0, "R5", "gate high with manual pulse", viol, 0);
    endtask

    task automatic run_meas(input int n, input int tail_d, input longint exp_c,
                            input string req);
        int m0;
        m0 = mp_total;
        strobe_start();
        train_then_stop(n, tail_d);
        finish_meas(m0, exp_c, DIV - int'(exp_c % DIV), 1'b0, req);
    endtask

    task automatic t_reset();
        chk(gate_en_o == 0, "R1", "gate_en_o", gate_en_o, 0);
        chk(man_pulse_o == 0, "R1", "man_pulse_o", man_pulse_o, 0);
        chk(valid_o == 0, "R1", "valid_o", valid_o, 0);
        chk(err_o == 0, "R1", "err_o", err_o, 0);
        chk(count_o == 0, "R1", "count_o", longint'(count_o), 0);
    endtask

    task automatic t_basic();
        run_meas(1000, 1, 1000, "R7");
        run_meas(255, 1, 255, "R7");
        run_meas(256, 1, 256, "R7");
        run_meas(0, 0, 0, "R7");
    endtask

    task automatic t_stop_race();
        for (int d = 0; d <= 4; d++) run_meas(2 * DIV, d, 2 * DIV, "R4");
    endtask

    task automatic t_start_ignored();
        int m0;
        m0 = mp_total;
        strobe_start();
        chk(gate_en_o == 1, "R2", "gate after start", gate_en_o, 1);
        pulses(300);
        strobe_start();
        chk(gate_en_o == 1, "R2", "gate after second start", gate_en_o, 1);
        pulses(100);
        strobe_stop();
        finish_meas(m0, 400, DIV - (400 % DIV), 1'b0, "R2");
    endtask

    task automatic t_start_stop_idle();
        int m0;
        m0 = mp_total;
        @(negedge clk) begin start_i = 1'b1; stop_i = 1'b1; end
        @(negedge clk) begin start_i = 1'b0; stop_i = 1'b0; end
        chk(gate_en_o == 1, "R2", "start wins over stop", gate_en_o, 1);
        pulses(5);
        strobe_stop();
        chk(gate_en_o == 0, "R3", "gate after stop", gate_en_o, 1'b0);
        finish_meas(m0, 5, DIV - 5, 1'b0, "R3");
    endtask

    task automatic t_stop_idle();
        int m0;
        int seen_v;
        int seen_g;
        m0 = mp_total; seen_v = 0; seen_g = 0;
        strobe_stop();
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (valid_o) seen_v++;
            if (gate_en_o) seen_g++;
        end
        chk(seen_v == 0, "R3", "valid after idle stop", seen_v, 0);
        chk(seen_g == 0, "R3", "gate after idle stop", seen_g, 0);
        chk(mp_total == m0, "R3", "manual pulses after idle stop", mp_total - m0, 0);
    endtask

    task automatic t_noise();
        int m0;
        m0 = mp_total;
        noise_en = 1'b1;
        repeat (60) @(negedge clk);
        noise_en = 1'b0;
        repeat (2) @(negedge clk);
        strobe_start();
        pulses(70);
        strobe_stop();
        noise_en = 1'b1;
        finish_meas(m0, 70, DIV - 70, 1'b0, "R10");
        noise_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_hold();
        longint c0;
        bit e0;
        bit got;
        run_meas(77, 1, 77, "R8");
        c0 = longint'(count_o); e0 = err_o;
        @(negedge clk);
        chk(valid_o == 0, "R8", "valid one cycle", valid_o, 0);
        got = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (valid_o || longint'(count_o) != c0 || err_o != e0) got = 1'b1;
        end
        chk(!got, "R8", "result held", longint'(got), 0);
    endtask

    // Prescaler output masked during recovery: no overflow ever returns.
    task automatic t_error();
        int m0;
        m0 = mp_total;
        strobe_start();
        pulses(300);
        strobe_stop();
        stuck = 1'b1;
        finish_meas(m0, DIV, DIV, 1'b1, "R9");
        stuck = 1'b0;
        // Prescaler received N blind pulses, so it still sits at 300 mod N = 44.
        m0 = mp_total;
        strobe_start();
        pulses(20);
        strobe_stop();
        finish_meas(m0, 64, DIV - 64, 1'b0, "R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_basic();
        t_stop_race();
        t_start_ignored();
        t_start_stop_idle();
        t_stop_idle();
        t_noise();
        t_hold();
        t_error();
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_total++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", 150000, 0);
        summary();
        $finish;
    end
endmodule